// File: doc/BRIEF.md
# Posted Store Buffer with Read-Ordering Drain

This block sits between a processor core and the bus master sequencer. The core posts stores into a small in-order queue and keeps executing; each store holds its address, data, byte size and a flag saying that more words of the same multi-word store follow. In the background the queue is emptied onto the bus as a stream of bus beats. Each beat carries a transfer type (idle, busy, non-sequential, sequential), a write flag, the address, the data and the size. A lone store goes out as one non-sequential beat followed by an idle beat. A multi-word store is held back until its final word has arrived, and then goes out as one unbroken burst.

When the core needs a bus load or an instruction fetch, it raises a read request. The block stalls the core until every queued store has reached the bus. It then issues the read's own non-sequential beat and releases the stall in the cycle that beat is accepted. If the read is a fetch that was waiting when the last store word went out, the store's trailing idle beat is dropped and the fetch beat follows directly.

Both streaming edges use valid/ready. The core store port moves a word only on a cycle with `wr_valid` and `wr_ready` both high. When `wr_ready` is low the word must be held and `core_stall` is raised. The sequencer side moves a beat only on a cycle with `seq_valid` and `seq_ready` both high. While `seq_ready` is low the offered beat stays unchanged, so the sequencer may insert any number of wait cycles.

Top module: `post_wbuf`

## Requirements
- R1: While fewer than DEPTH stores are queued, `wr_ready` is high and a store is taken in one cycle. With DEPTH queued, `wr_ready` is low and `core_stall` is high for as long as `wr_valid` is held; the store is taken once a write beat has been accepted.
- R2: Write beats leave in exactly the order the stores were taken. Each carries the store's address, data and size (size encoding: 0 byte, 1 halfword, 2 word), with `seq_write` high.
- R3: A store taken with `wr_cont` low, not preceded by a store with `wr_cont` high, drains as one beat of type 2 (non-sequential) followed by one beat of type 0 (idle).
- R4: Stores with `wr_cont` high, together with the following store with `wr_cont` low, form one burst. No beat of that burst is offered before its final word is taken. The burst drains as type 2, then one type 3 (sequential) beat per further word, each at the previous address plus 4, then one type 0 beat.
- R5: A burst word other than the first whose address has its low REGION_BITS bits all zero is preceded by one type 0 beat and is itself sent as type 2.
- R6: A read beat (type 2, `seq_write` low, address `rd_addr`, size 2) is offered only after every queued store beat and its trailing beats have been accepted.
- R7: After a data read (`rd_fetch` low) the next beat is type 0. After a fetch (`rd_fetch` high) the next beat is type 1 (busy).
- R8: If a fetch request is pending when the last queued store word's beat is accepted, no trailing idle beat is sent, and the fetch's type 2 beat is the next one.
- R9: While `rd_req` is high, `core_stall` is high, except in the cycle the read beat is accepted. In that cycle `rd_done` is high and `core_stall` is low.
- R10: A beat offered with `seq_ready` low is offered again unchanged in the next cycle. `seq_valid` stays low while nothing is ready to send.
- R11: After reset the queue is empty, `wr_ready` is high, and `seq_valid`, `core_stall` and `rd_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Core offers a store |
| wr_ready | output | 1 | Store queue can take the offered store |
| wr_addr | input | ADDR_W | Store address |
| wr_data | input | DATA_W | Store data |
| wr_size | input | 2 | Store size: 0 byte, 1 halfword, 2 word |
| wr_cont | input | 1 | More words of this multi-word store follow |
| rd_req | input | 1 | Core needs a bus read; held until rd_done |
| rd_fetch | input | 1 | Read is an instruction fetch (1) or data load (0) |
| rd_addr | input | ADDR_W | Read address |
| core_stall | output | 1 | Core must wait |
| rd_done | output | 1 | Read beat accepted this cycle |
| seq_valid | output | 1 | A bus beat is offered |
| seq_ready | input | 1 | Sequencer accepts the offered beat |
| seq_trans | output | 2 | Transfer type: 0 idle, 1 busy, 2 non-sequential, 3 sequential |
| seq_write | output | 1 | Beat is a store |
| seq_addr | output | ADDR_W | Beat address |
| seq_data | output | DATA_W | Beat store data |
| seq_size | output | 2 | Beat size |

## Verification
The assertions assume a well-behaved core. It keeps `rd_req`, `rd_fetch` and `rd_addr` steady from the request until `rd_done`, offers no store while a read is pending, and never raises a read while a multi-word store is only partly posted. Burst words step by 4 bytes, and no burst is longer than DEPTH. The bench posts every burst in consecutive cycles before raising a read. It drops the request one cycle after `rd_done`, keeps its burst lengths within DEPTH, and leaves the sequencer's ready pattern unconstrained.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  typedef enum logic [2:0] {
    DR_IDLE,    // waiting for a closed group or a read
    DR_GRP,     // inside a burst, next word sequential
    DR_GRPN,    // inside a burst, after a region break
    DR_TRAIL,   // trailing idle after a store group
    DR_RDN,     // read beat
    DR_RTRAIL   // trailing beat after a read
  } drain_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [1:0]        size;
    logic              cont;
  } entry_t;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  entry_t           push_ent,
  input  logic             pop,
  output entry_t           head,
  output logic [CNT_W-1:0] count,
  output logic             closed_any
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  entry_t           mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] closed_n;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[wp] <= push_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      closed_n <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count    <= count + CNT_W'(push) - CNT_W'(pop);
      closed_n <= closed_n + CNT_W'(push && !push_ent.cont)
                           - CNT_W'(pop && !head.cont);
    end
  end

  assign head       = mem[rp];
  assign closed_any = (closed_n != '0);
endmodule

// File: rtl/wbuf_core_if.sv
module wbuf_core_if #(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             wr_valid,
  input  logic [CNT_W-1:0] count,
  input  logic             rd_req,
  input  logic             rd_done,
  output logic             wr_ready,
  output logic             push,
  output logic             core_stall
);
  logic full;

  assign full       = (count == CNT_W'(DEPTH));
  assign wr_ready   = !full;
  assign push       = wr_valid && wr_ready;
  assign core_stall = (rd_req && !rd_done) || (wr_valid && !wr_ready);
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
  import wbuf_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int REGION_BITS = 10,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  entry_t            head,
  input  logic [CNT_W-1:0]  count,
  input  logic              closed_any,
  input  logic              push,
  input  logic              rd_req,
  input  logic              rd_fetch,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              seq_ready,
  output logic              seq_valid,
  output trans_e            seq_trans,
  output logic              seq_write,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [DATA_W-1:0] seq_data,
  output logic [1:0]        seq_size,
  output logic              pop,
  output logic              rd_done
);
  drain_st_e st, st_n;
  logic      rk_fetch;
  logic      hs, at_bound, last_word;
  drain_st_e after_last, after_word;

  assign hs         = seq_valid && seq_ready;
  assign at_bound   = (head.addr[REGION_BITS-1:0] == '0);
  assign last_word  = (count == CNT_W'(1)) && !push;
  assign after_last = (last_word && rd_req && rd_fetch) ? DR_RDN : DR_TRAIL;
  assign after_word = head.cont ? DR_GRP : after_last;

  always_comb begin
    st_n      = st;
    seq_valid = 1'b0;
    seq_trans = TR_IDLE;
    seq_write = 1'b0;
    seq_addr  = '0;
    seq_data  = '0;
    seq_size  = '0;
    pop       = 1'b0;
    rd_done   = 1'b0;
    case (st)
      DR_IDLE: begin
        if (closed_any) begin
          seq_valid = 1'b1;
          seq_trans = TR_NONSEQ;
          seq_write = 1'b1;
          seq_addr  = head.addr;
          seq_data  = head.data;
          seq_size  = head.size;
          if (hs) begin
            pop  = 1'b1;
            st_n = after_word;
          end
        end else if ((count == '0) && rd_req) begin
          seq_valid = 1'b1;
          seq_trans = TR_NONSEQ;
          seq_addr  = rd_addr;
          seq_size  = 2'd2;
          if (hs) begin
            rd_done = 1'b1;
            st_n    = DR_RTRAIL;
          end
        end
      end
      DR_GRP: begin
        seq_valid = 1'b1;
        if (at_bound) begin
          seq_trans = TR_IDLE;
          if (hs) st_n = DR_GRPN;
        end else begin
          seq_trans = TR_SEQ;
          seq_write = 1'b1;
          seq_addr  = head.addr;
          seq_data  = head.data;
          seq_size  = head.size;
          if (hs) begin
            pop  = 1'b1;
            st_n = after_word;
          end
        end
      end
      DR_GRPN: begin
        seq_valid = 1'b1;
        seq_trans = TR_NONSEQ;
        seq_write = 1'b1;
        seq_addr  = head.addr;
        seq_data  = head.data;
        seq_size  = head.size;
        if (hs) begin
          pop  = 1'b1;
          st_n = after_word;
        end
      end
      DR_TRAIL: begin
        seq_valid = 1'b1;
        seq_trans = TR_IDLE;
        if (hs) st_n = DR_IDLE;
      end
      DR_RDN: begin
        seq_valid = 1'b1;
        seq_trans = TR_NONSEQ;
        seq_addr  = rd_addr;
        seq_size  = 2'd2;
        if (hs) begin
          rd_done = 1'b1;
          st_n    = DR_RTRAIL;
        end
      end
      DR_RTRAIL: begin
        seq_valid = 1'b1;
        seq_trans = rk_fetch ? TR_BUSY : TR_IDLE;
        if (hs) st_n = DR_IDLE;
      end
      default: st_n = DR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= DR_IDLE;
      rk_fetch <= 1'b0;
    end else begin
      st <= st_n;
      if (rd_done) rk_fetch <= rd_fetch;
    end
  end
endmodule

// File: rtl/post_wbuf.sv
module post_wbuf
  import wbuf_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int REGION_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_size,
  input  logic              wr_cont,
  input  logic              rd_req,
  input  logic              rd_fetch,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              core_stall,
  output logic              rd_done,
  output logic              seq_valid,
  input  logic              seq_ready,
  output logic [1:0]        seq_trans,
  output logic              seq_write,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [DATA_W-1:0] seq_data,
  output logic [1:0]        seq_size
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  entry_t           push_ent, head;
  logic [CNT_W-1:0] count;
  logic             closed_any, push, pop;
  trans_e           trans;

  assign push_ent = '{addr: wr_addr, data: wr_data, size: wr_size, cont: wr_cont};

  wbuf_core_if #(.DEPTH(DEPTH), .CNT_W(CNT_W)) core_if_i (
    .wr_valid   (wr_valid),
    .count      (count),
    .rd_req     (rd_req),
    .rd_done    (rd_done),
    .wr_ready   (wr_ready),
    .push       (push),
    .core_stall (core_stall)
  );

  wbuf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_ent   (push_ent),
    .pop        (pop),
    .head       (head),
    .count      (count),
    .closed_any (closed_any)
  );

  wbuf_drain #(.DEPTH(DEPTH), .REGION_BITS(REGION_BITS), .CNT_W(CNT_W)) drain_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .head       (head),
    .count      (count),
    .closed_any (closed_any),
    .push       (push),
    .rd_req     (rd_req),
    .rd_fetch   (rd_fetch),
    .rd_addr    (rd_addr),
    .seq_ready  (seq_ready),
    .seq_valid  (seq_valid),
    .seq_trans  (trans),
    .seq_write  (seq_write),
    .seq_addr   (seq_addr),
    .seq_data   (seq_data),
    .seq_size   (seq_size),
    .pop        (pop),
    .rd_done    (rd_done)
  );

  assign seq_trans = trans;
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_req,
  input logic              rd_fetch,
  input logic              core_stall,
  input logic              rd_done,
  input logic              seq_valid,
  input logic              seq_ready,
  input logic [1:0]        seq_trans,
  input logic              seq_write,
  input logic [ADDR_W-1:0] seq_addr,
  input logic [DATA_W-1:0] seq_data
);
  localparam int OCC_W = $clog2(DEPTH + 1) + 1;

  logic [OCC_W-1:0]  occ;
  logic [ADDR_W-1:0] last_waddr;
  logic              last_fetch;
  logic              hs, wr_hs, wr_push, rd_hs;

  assign hs      = seq_valid && seq_ready;
  assign wr_hs   = hs && seq_write;
  assign wr_push = wr_valid && wr_ready;
  assign rd_hs   = hs && !seq_write && (seq_trans == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ        <= '0;
      last_waddr <= '0;
      last_fetch <= 1'b0;
    end else begin
      occ <= occ + OCC_W'(wr_push) - OCC_W'(wr_hs);
      if (wr_hs) last_waddr <= seq_addr;
      if (rd_hs)   last_fetch <= rd_fetch;
      else if (hs) last_fetch <= 1'b0;
    end
  end

  p_space_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < OCC_W'(DEPTH)) |-> wr_ready);

  p_full_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(DEPTH)) && wr_valid |-> core_stall && !wr_ready);

  p_seq_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && (seq_trans == 2'd3) |-> seq_write && (seq_addr == last_waddr + 4));

  p_read_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && !seq_write && (seq_trans == 2'd2) |-> (occ == '0));

  p_busy_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && (seq_trans == 2'd1) |-> last_fetch);

  p_stall_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_done |-> core_stall);

  p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_hs && !core_stall);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && !seq_ready |=> seq_valid && $stable(seq_trans) && $stable(seq_write)
                                && $stable(seq_addr) && $stable(seq_data));
endmodule

bind post_wbuf wbuf_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .rd_req     (rd_req),
  .rd_fetch   (rd_fetch),
  .core_stall (core_stall),
  .rd_done    (rd_done),
  .seq_valid  (seq_valid),
  .seq_ready  (seq_ready),
  .seq_trans  (seq_trans),
  .seq_write  (seq_write),
  .seq_addr   (seq_addr),
  .seq_data   (seq_data)
);

// File: tb/post_wbuf_tb_top.sv
module post_wbuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int LOGN       = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_ready, wr_cont = 1'b0;
  logic [31:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [1:0]  wr_size = '0;
  logic        rd_req = 1'b0, rd_fetch = 1'b0;
  logic        core_stall, rd_done, seq_valid, seq_write;
  logic        seq_ready = 1'b0;
  logic [1:0]  seq_trans, seq_size;
  logic [31:0] seq_addr, seq_data;

  post_wbuf #(.DEPTH(DEPTH), .REGION_BITS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size), .wr_cont(wr_cont),
    .rd_req(rd_req), .rd_fetch(rd_fetch), .rd_addr(rd_addr),
    .core_stall(core_stall), .rd_done(rd_done), .seq_valid(seq_valid),
    .seq_ready(seq_ready), .seq_trans(seq_trans), .seq_write(seq_write),
    .seq_addr(seq_addr), .seq_data(seq_data), .seq_size(seq_size)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, rmod = 1;
  bit hold_ready = 1'b1;

  always begin
    @(posedge clk); #1;
    cyc = cyc + 1;
    seq_ready = !hold_ready && ((cyc % rmod) == 0);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // beat log from the monitor, expectations from the stimulus
  logic [1:0]  lg_tr [LOGN];
  logic        lg_w  [LOGN];
  logic [31:0] lg_a  [LOGN];
  logic [31:0] lg_d  [LOGN];
  logic [1:0]  lg_s  [LOGN];
  int          lg_n = 0;
  logic [1:0]  ex_tr [LOGN];
  logic        ex_w  [LOGN];
  logic [31:0] ex_a  [LOGN];
  logic [31:0] ex_d  [LOGN];
  logic [1:0]  ex_s  [LOGN];
  string       ex_req[LOGN];
  int          ex_n = 0;

  bit          pend = 1'b0;
  logic [1:0]  sv_tr;
  logic        sv_w;
  logic [31:0] sv_a, sv_d;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend)
        chk(seq_valid && seq_trans == sv_tr && seq_write == sv_w && seq_addr == sv_a
            && seq_data == sv_d, "R10", "held beat", seq_addr, sv_a);
      pend  = seq_valid && !seq_ready;
      sv_tr = seq_trans; sv_w = seq_write; sv_a = seq_addr; sv_d = seq_data;
      if (seq_valid && seq_ready) begin
        if (lg_n < LOGN) begin
          lg_tr[lg_n] = seq_trans; lg_w[lg_n] = seq_write; lg_a[lg_n] = seq_addr;
          lg_d[lg_n] = seq_data; lg_s[lg_n] = seq_size;
        end
        lg_n++;
      end
      if (rd_req && !wr_valid) begin
        if (seq_valid && seq_ready && !seq_write && seq_trans == 2'd2)
          chk(rd_done && !core_stall, "R9", "release at read accept",
              {30'd0, rd_done, core_stall}, 32'd2);
        else
          chk(core_stall && !rd_done, "R9", "stall while read pending",
              {30'd0, rd_done, core_stall}, 32'd1);
      end
    end
  end

  task automatic add_ex(input logic [1:0] tr, input logic w, input logic [31:0] a,
                        input logic [31:0] d, input logic [1:0] s, input string req);
    ex_tr[ex_n] = tr; ex_w[ex_n] = w; ex_a[ex_n] = a; ex_d[ex_n] = d;
    ex_s[ex_n] = s; ex_req[ex_n] = req;
    ex_n++;
  endtask

  // called just after a rising edge; returns the cycles spent waiting
  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s,
                      input logic c, output int waits);
    bit acc;
    waits = 0;
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_size = s; wr_cont = c;
    forever begin
      @(negedge clk); acc = wr_ready;
      @(posedge clk); #1;
      if (acc) break;
      waits++;
    end
    wr_valid = 1'b0; wr_cont = 1'b0;
  endtask

  task automatic finish_and_compare();
    int t = 0;
    while (lg_n < ex_n && t < 400) begin @(posedge clk); #1; t++; end
    repeat (6) begin @(posedge clk); #1; end
    chk(lg_n == ex_n, "R2", "beat count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      chk(lg_tr[i] == ex_tr[i] && lg_w[i] == ex_w[i], ex_req[i], "beat type",
          {29'd0, lg_w[i], lg_tr[i]}, {29'd0, ex_w[i], ex_tr[i]});
      if (ex_tr[i] >= 2'd2)
        chk(lg_a[i] == ex_a[i], ex_req[i], "beat address", lg_a[i], ex_a[i]);
      if (ex_w[i])
        chk(lg_d[i] == ex_d[i] && lg_s[i] == ex_s[i], "R2", "beat data/size",
            lg_d[i], ex_d[i]);
    end
    lg_n = 0; ex_n = 0;
  endtask

  // n-word store, j words before a 1 KB boundary, read kind k, ready every m cycles
  task automatic run_scen(input int n, input int j, input int k, input int m, input int sid);
    logic [31:0] base, a, d;
    int w;
    bit got;
    base = 32'h0001_0400 - 32'(4 * j);
    rmod = m;
    for (int i = 0; i < n; i++) begin
      a = base + 32'(4 * i);
      d = 32'hA000_0000 + 32'(sid * 16 + i);
      push(a, d, 2'd2, (i < n - 1), w);
      if (i == 0)
        add_ex(2'd2, 1'b1, a, d, 2'd2, (n == 1) ? "R3" : "R4");
      else if (a[9:0] == 10'd0) begin
        add_ex(2'd0, 1'b0, 32'd0, 32'd0, 2'd0, "R5");
        add_ex(2'd2, 1'b1, a, d, 2'd2, "R5");
      end else
        add_ex(2'd3, 1'b1, a, d, 2'd2, "R4");
    end
    if (k == 2) begin
      add_ex(2'd2, 1'b0, 32'h0000_8000 + 32'(sid), 32'd0, 2'd2, "R8");
      add_ex(2'd1, 1'b0, 32'd0, 32'd0, 2'd0, "R7");
    end else begin
      add_ex(2'd0, 1'b0, 32'd0, 32'd0, 2'd0, (n == 1) ? "R3" : "R4");
      if (k == 1) begin
        add_ex(2'd2, 1'b0, 32'h0000_8000 + 32'(sid), 32'd0, 2'd2, "R6");
        add_ex(2'd0, 1'b0, 32'd0, 32'd0, 2'd0, "R7");
      end
    end
    if (k != 0) begin
      rd_fetch = (k == 2);
      rd_addr  = 32'h0000_8000 + 32'(sid);
      rd_req   = 1'b1;
      w = 0;
      forever begin
        @(negedge clk); got = rd_done;
        @(posedge clk); #1;
        w++;
        if (got || w > 400) break;
      end
      chk(got, "R9", "rd_done seen", {31'd0, got}, 32'd1);
      rd_req = 1'b0; rd_fetch = 1'b0;
    end
    finish_and_compare();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    int w, sid;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready && !seq_valid && !core_stall && !rd_done, "R11", "reset state",
        {28'd0, wr_ready, seq_valid, core_stall, rd_done}, 32'h8);
    @(posedge clk); #1;

    // R1: fill while the sequencer refuses, then overflow attempt
    hold_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      push(32'h200 + 32'(4 * i), 32'hB000_0000 + 32'(i), 2'(i % 3), 1'b0, w);
      chk(w == 0, "R1", "store taken while space", w, 0);
      add_ex(2'd2, 1'b1, 32'h200 + 32'(4 * i), 32'hB000_0000 + 32'(i), 2'(i % 3), "R3");
      add_ex(2'd0, 1'b0, 32'd0, 32'd0, 2'd0, "R3");
    end
    wr_valid = 1'b1; wr_addr = 32'h210; wr_data = 32'hB000_0004; wr_size = 2'd2;
    repeat (3) begin
      @(negedge clk);
      chk(!wr_ready && core_stall, "R1", "full queue stalls",
          {30'd0, wr_ready, core_stall}, 32'd1);
      chk(!seq_ready || !seq_valid, "R10", "no accept while held off", seq_ready, 0);
      @(posedge clk); #1;
    end
    hold_ready = 1'b0; rmod = 1;
    push(32'h210, 32'hB000_0004, 2'd2, 1'b0, w);
    chk(w >= 1 && w <= 3, "R1", "store taken after a beat frees space", w, 1);
    add_ex(2'd2, 1'b1, 32'h210, 32'hB000_0004, 2'd2, "R2");
    add_ex(2'd0, 1'b0, 32'd0, 32'd0, 2'd0, "R3");
    finish_and_compare();

    // R4: an open burst is held back until its final word arrives
    push(32'h100, 32'hC000_0000, 2'd2, 1'b1, w);
    push(32'h104, 32'hC000_0001, 2'd2, 1'b1, w);
    repeat (5) begin
      @(negedge clk);
      chk(!seq_valid, "R4", "open burst not offered", seq_valid, 0);
      @(posedge clk); #1;
    end
    push(32'h108, 32'hC000_0002, 2'd2, 1'b0, w);
    add_ex(2'd2, 1'b1, 32'h100, 32'hC000_0000, 2'd2, "R4");
    add_ex(2'd3, 1'b1, 32'h104, 32'hC000_0001, 2'd2, "R4");
    add_ex(2'd3, 1'b1, 32'h108, 32'hC000_0002, 2'd2, "R4");
    add_ex(2'd0, 1'b0, 32'd0, 32'd0, 2'd0, "R4");
    finish_and_compare();

    // sweep: length x boundary offset x read kind x ready pattern
    sid = 0;
    for (int n = 1; n <= DEPTH; n++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 3; k++)
          for (int m = 1; m <= 3; m++) begin
            run_scen(n, j, k, m, sid);
            sid++;
          end

    summary();
    $finish;
  end
endmodule